// File: doc/BRIEF.md
# Zero-Overhead Loop Repeat Controller

This block runs a hardware repeat loop for a pipeline that fetches 16-bit instructions. It holds three registers: the loop start address, the loop end address and a 12-bit iteration counter. Each cycle it looks at the address being fetched. When that address is the loop end, the loop is live and at least two passes remain, the next fetch goes back to the loop start and the counter drops by one. This costs no extra instruction or cycle. On the last pass, fetch falls through and the loop shuts down. If the end instruction sits in the delay slot of a taken branch, the repeat is skipped and fetch goes to the branch target.

The block also produces the program-counter value that the current instruction would read. With no loop running this value is the fetch address plus 4. After a loop-back it follows a degraded pattern that depends on the loop-length class, which is fixed when the counter is loaded. A loop of up to three instructions is short; a loop of four or more is long.

Fetch data arrives as a plain per-cycle strobe (`fetch_vld`) with no ready signal. The controller never stalls, so there is no back-pressure. When the strobe is low, `next_addr` simply reports the sequential address and no internal state moves. Register writes use a one-cycle strobe. The next-address and reported-PC outputs are combinational from the fetch inputs and the registered state.

Top module: `rpt_ctrl`

## Requirements
- R1: After reset the counter is 0, `loop_act` is low, `next_addr` equals `fetch_addr`+2 and `rpt_pc` equals `fetch_addr`+4.
- R2: When no loop-back and no taken delay-slot branch applies, `next_addr` equals `fetch_addr`+2.
- R3: A write with `wr_en` high uses `wr_sel` to pick the target: 0 is the start address, 1 is the end address, 2 is the counter (`wr_data[11:0]`), and 3 is ignored. The write takes effect on the next cycle. A counter write restarts the iteration count, and has priority over a loop-back decrement in the same cycle. `loop_act` is high exactly when the counter is nonzero.
- R4: A valid fetch at the end address, with the loop active and the counter at 2 or more, gives `next_addr` equal to the start address, and the counter decrements by one.
- R5: A valid fetch at the end address with the counter at 1 gives `next_addr` equal to `fetch_addr`+2. The counter is cleared and `loop_act` falls on the next cycle.
- R6: A valid fetch with `in_slot` and `br_taken` both high gives `next_addr` equal to `br_tgt`. At the end address no loop-back happens and the counter is unchanged.
- R7: An end-address fetch with `in_slot` high and `br_taken` low loops back exactly as in R4.
- R8: `rpt_pc` equals `fetch_addr`+4 while no loop is active, and throughout the first pass after a counter load.
- R9: In a short loop (end minus start of 4 or less), the first fetch after a loop-back reports its own address +4. Every later fetch up to the next end-address fetch reports the start address.
- R10: In a long loop, the first fetch after a loop-back reports its address +4. The second and third fetches report the start address and the start address +2. Later fetches report their address +4.
- R11: The length class is taken from the start and end registers when the counter is written. Later changes to the start or end address do not alter it until the next counter write.
- R12: While `fetch_vld` is low, the counter and the PC-reporting phase do not change, and `next_addr` equals `fetch_addr`+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_vld | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 32 | Address of the instruction being fetched |
| in_slot | input | 1 | Instruction is in a branch delay slot |
| br_taken | input | 1 | The owning branch is taken |
| br_tgt | input | 32 | Target of the owning branch |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 start, 1 end, 2 counter, 3 none |
| wr_data | input | 32 | Write data |
| next_addr | output | 32 | Address to fetch next |
| loop_act | output | 1 | A repeat loop is in progress |
| rpt_pc | output | 32 | PC value seen by the current instruction |

## Verification
Directed loops of one, three, four and eight instructions are run to exhaustion. These separate the short and long PC patterns, and also separate loop-back from the final fall-through. A delay-slot end instruction is tried with the branch taken and with it not taken, which tells a suppressed repeat apart from a normal one. A mid-loop change of the end address checks that the length class stays latched. Random loops with random fetch gaps, delay slots, taken branches and counter rewrites then compare every cycle's `next_addr`, `rpt_pc` and `loop_act` against a bench model. This catches ordering faults between the write priority and the decrement.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_END   = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_NONE  = 2'd3
  } wr_sel_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2,
    PH_THIRD  = 2'd3
  } ph_e;

endpackage

// File: rtl/rpt_regs.sv
module rpt_regs
  import rpt_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CW        = 12,
  parameter int SHORT_MAX = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          dec,
  input  logic          clr,
  output logic [AW-1:0] rs_q,
  output logic [AW-1:0] re_q,
  output logic [CW-1:0] rc_q,
  output logic          short_q,
  output logic          rc_wr
);

  localparam logic [AW-1:0] SPAN = AW'((SHORT_MAX - 1) * 2);

  wr_sel_e sel;
  logic    span_short;

  assign sel        = wr_sel_e'(wr_sel);
  assign rc_wr      = wr_en && (sel == SEL_COUNT);
  assign span_short = (re_q - rs_q) <= SPAN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
      re_q <= '0;
    end else if (wr_en) begin
      if (sel == SEL_START) rs_q <= wr_data;
      if (sel == SEL_END)   re_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q    <= '0;
      short_q <= 1'b0;
    end else if (rc_wr) begin
      rc_q    <= wr_data[CW-1:0];
      short_q <= span_short;
    end else if (clr) begin
      rc_q <= '0;
    end else if (dec) begin
      rc_q <= rc_q - CW'(1);
    end
  end

endmodule

// File: rtl/rpt_seq.sv
module rpt_seq #(
  parameter int AW = 32,
  parameter int CW = 12
) (
  input  logic          fetch_vld,
  input  logic [AW-1:0] fetch_addr,
  input  logic          in_slot,
  input  logic          br_taken,
  input  logic [AW-1:0] br_tgt,
  input  logic [AW-1:0] rs_q,
  input  logic [AW-1:0] re_q,
  input  logic [CW-1:0] rc_q,
  output logic [AW-1:0] next_addr,
  output logic          loop_back,
  output logic          loop_exit,
  output logic          at_end
);

  logic live;
  logic hit;
  logic sup;
  logic more;

  assign live = rc_q != '0;
  assign hit  = fetch_vld && live && (fetch_addr == re_q);
  assign sup  = fetch_vld && in_slot && br_taken;
  assign more = rc_q > CW'(1);

  assign at_end    = hit;
  assign loop_back = hit && !sup && more;
  assign loop_exit = hit && !sup && !more;

  always_comb begin
    if (sup)            next_addr = br_tgt;
    else if (loop_back) next_addr = rs_q;
    else                next_addr = fetch_addr + AW'(2);
  end

endmodule

// File: rtl/rpt_pcrep.sv
module rpt_pcrep
  import rpt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_vld,
  input  logic [AW-1:0] fetch_addr,
  input  logic [AW-1:0] rs_q,
  input  logic          short_q,
  input  logic          rc_wr,
  input  logic          loop_back,
  input  logic          at_end,
  output logic [AW-1:0] rpt_pc
);

  ph_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (rc_wr) begin
      ph_d = PH_IDLE;
    end else if (fetch_vld) begin
      if (loop_back)             ph_d = PH_FIRST;
      else if (at_end)           ph_d = PH_IDLE;
      else if (ph_q == PH_IDLE)  ph_d = PH_IDLE;
      else if (short_q)          ph_d = PH_SECOND;
      else begin
        case (ph_q)
          PH_FIRST:  ph_d = PH_SECOND;
          PH_SECOND: ph_d = PH_THIRD;
          default:   ph_d = PH_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  always_comb begin
    case (ph_q)
      PH_SECOND: rpt_pc = rs_q;
      PH_THIRD:  rpt_pc = short_q ? rs_q : rs_q + AW'(2);
      default:   rpt_pc = fetch_addr + AW'(4);
    endcase
  end

endmodule

// File: rtl/rpt_ctrl.sv
module rpt_ctrl #(
  parameter int AW        = 32,
  parameter int CW        = 12,
  parameter int SHORT_MAX = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_vld,
  input  logic [AW-1:0] fetch_addr,
  input  logic          in_slot,
  input  logic          br_taken,
  input  logic [AW-1:0] br_tgt,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] next_addr,
  output logic          loop_act,
  output logic [AW-1:0] rpt_pc
);

  logic [AW-1:0] rs_q;
  logic [AW-1:0] re_q;
  logic [CW-1:0] rc_q;
  logic          short_q;
  logic          rc_wr;
  logic          loop_back;
  logic          loop_exit;
  logic          at_end;

  rpt_regs #(.AW(AW), .CW(CW), .SHORT_MAX(SHORT_MAX)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .dec     (loop_back),
    .clr     (loop_exit),
    .rs_q    (rs_q),
    .re_q    (re_q),
    .rc_q    (rc_q),
    .short_q (short_q),
    .rc_wr   (rc_wr)
  );

  rpt_seq #(.AW(AW), .CW(CW)) u_seq (
    .fetch_vld  (fetch_vld),
    .fetch_addr (fetch_addr),
    .in_slot    (in_slot),
    .br_taken   (br_taken),
    .br_tgt     (br_tgt),
    .rs_q       (rs_q),
    .re_q       (re_q),
    .rc_q       (rc_q),
    .next_addr  (next_addr),
    .loop_back  (loop_back),
    .loop_exit  (loop_exit),
    .at_end     (at_end)
  );

  rpt_pcrep #(.AW(AW)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_vld  (fetch_vld),
    .fetch_addr (fetch_addr),
    .rs_q       (rs_q),
    .short_q    (short_q),
    .rc_wr      (rc_wr),
    .loop_back  (loop_back),
    .at_end     (at_end),
    .rpt_pc     (rpt_pc)
  );

  assign loop_act = rc_q != '0;

endmodule

// File: rtl/rpt_ctrl_chk.sv
module rpt_ctrl_chk #(
  parameter int AW = 32,
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_vld,
  input logic [AW-1:0] fetch_addr,
  input logic          in_slot,
  input logic          br_taken,
  input logic [AW-1:0] br_tgt,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [AW-1:0] wr_data,
  input logic [AW-1:0] rs,
  input logic [AW-1:0] re,
  input logic [CW-1:0] rc,
  input logic [AW-1:0] next_addr,
  input logic          loop_act,
  input logic [AW-1:0] rpt_pc
);

  logic hit, sup, cnt_wr;
  assign hit    = fetch_vld && loop_act && (fetch_addr == re);
  assign sup    = fetch_vld && in_slot && br_taken;
  assign cnt_wr = wr_en && (wr_sel == 2'd2);

  // R4 and R7: loop-back target
  a_r4_loop_target: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !sup && rc > CW'(1)) |-> next_addr == rs);

  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !sup && rc > CW'(1) && !cnt_wr) |=> rc == $past(rc) - CW'(1));

  a_r5_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !sup && rc == CW'(1) && !cnt_wr) |=> !loop_act);

  a_r6_branch_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sup |-> next_addr == br_tgt);

  a_r6_count_held: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sup && !cnt_wr) |=> $stable(rc));

  a_r3_count_write: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> rc == $past(wr_data[CW-1:0]));

  a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_act && !sup) |-> next_addr == fetch_addr + AW'(2));

  a_r8_idle_pc: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_act |-> rpt_pc == fetch_addr + AW'(4));

  a_r12_idle_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_vld && !wr_en) |=> $stable(rc));

endmodule

bind rpt_ctrl rpt_ctrl_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetch_vld  (fetch_vld),
  .fetch_addr (fetch_addr),
  .in_slot    (in_slot),
  .br_taken   (br_taken),
  .br_tgt     (br_tgt),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .rs         (rs_q),
  .re         (re_q),
  .rc         (rc_q),
  .next_addr  (next_addr),
  .loop_act   (loop_act),
  .rpt_pc     (rpt_pc)
);

// File: tb/sim_rpt_ctrl.sv
`timescale 1ns/1ps
module sim_rpt_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_vld = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        in_slot = 1'b0;
  logic        br_taken = 1'b0;
  logic [31:0] br_tgt = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [31:0] wr_data = '0;
  logic [31:0] next_addr;
  logic        loop_act;
  logic [31:0] rpt_pc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] m_rs = '0, m_re = '0;
  int          m_rc = 0;
  bit          m_short = 1'b0;
  int          m_ph = 0;

  always #2.5 clk = ~clk;

  rpt_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
    .in_slot(in_slot), .br_taken(br_taken), .br_tgt(br_tgt),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .next_addr(next_addr), .loop_act(loop_act), .rpt_pc(rpt_pc)
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pc(logic [31:0] a);
    if (m_ph <= 1) return a + 32'd4;
    if (m_short)   return m_rs;
    return (m_ph == 2) ? m_rs : m_rs + 32'd2;
  endfunction

  task automatic step(bit v, logic [31:0] a, bit sl, bit tk, logic [31:0] tg,
                      bit we, logic [1:0] ws, logic [31:0] wd, output logic [31:0] nx);
    bit det, sup;
    int n_rc, n_ph;
    logic [31:0] e_nx, e_pc;
    string tag;
    @(negedge clk);
    fetch_vld = v; fetch_addr = a; in_slot = sl; br_taken = tk; br_tgt = tg;
    wr_en = we; wr_sel = ws; wr_data = wd;
    #1;
    det = v && (m_rc != 0) && (a == m_re);
    sup = v && sl && tk;
    if (sup) begin e_nx = tg; tag = "R6"; end
    else if (det && m_rc >= 2) begin e_nx = m_rs; tag = sl ? "R7" : "R4"; end
    else if (det) begin e_nx = a + 32'd2; tag = "R5"; end
    else begin e_nx = a + 32'd2; tag = v ? "R2" : "R12"; end
    e_pc = exp_pc(a);
    chk(next_addr === e_nx, tag, "next_addr", next_addr, e_nx);
    chk(rpt_pc === e_pc, (m_ph == 0) ? "R8" : (m_short ? "R9 R11" : "R10 R11"),
        "rpt_pc", rpt_pc, e_pc);
    chk(loop_act === (m_rc != 0), "R3", "loop_act", {31'd0, loop_act}, {31'd0, m_rc != 0});
    nx = v ? e_nx : a;
    @(posedge clk);
    n_rc = m_rc; n_ph = m_ph;
    if (v) begin
      if (det && !sup && m_rc >= 2) begin n_rc = m_rc - 1; n_ph = 1; end
      else if (det && !sup) begin n_rc = 0; n_ph = 0; end
      else if (det) n_ph = 0;
      else if (m_ph == 0) n_ph = 0;
      else if (m_short) n_ph = 2;
      else n_ph = (m_ph == 3) ? 0 : m_ph + 1;
    end
    if (we) begin
      if (ws == 2'd0) m_rs = wd;
      if (ws == 2'd1) m_re = wd;
      if (ws == 2'd2) begin
        n_rc = int'(wd[11:0]);
        m_short = (m_re - m_rs) <= 32'd4;
        n_ph = 0;
      end
    end
    m_rc = n_rc; m_ph = n_ph;
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    logic [31:0] nx;
    step(1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, s, d, nx);
  endtask

  // walk a program from pc for n cycles; slot/branch knobs for the end instruction
  task automatic walk(logic [31:0] start, int n, bit end_slot, bit end_tk, logic [31:0] tg);
    logic [31:0] pc, nx;
    bit at;
    pc = start;
    for (int i = 0; i < n; i++) begin
      at = (pc == m_re);
      step(1'b1, pc, at && end_slot, at && end_tk, tg, 1'b0, 2'd3, 32'h0, nx);
      pc = nx;
    end
  endtask

  task automatic setup(logic [31:0] s, logic [31:0] e, int c);
    wr(2'd0, s);
    wr(2'd1, e);
    wr(2'd2, c);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] nx, pc;
    void'($urandom(32'd1234));
    #12;
    // R1: reset state
    fetch_vld = 1'b1; fetch_addr = 32'h40; #1;
    chk(next_addr === 32'h42, "R1", "next_addr", next_addr, 32'h42);
    chk(rpt_pc === 32'h44, "R1", "rpt_pc", rpt_pc, 32'h44);
    chk(loop_act === 1'b0, "R1", "loop_act", {31'd0, loop_act}, 32'd0);
    rst_n = 1'b1;
    // R3: ignored select 3
    wr(2'd3, 32'h5);
    chk(loop_act === 1'b0, "R3", "sel3 ignored", {31'd0, loop_act}, 32'd0);
    // R9: short loop of three, R4 R5 exhaustion
    setup(32'h100, 32'h104, 3);
    walk(32'h100, 14, 1'b0, 1'b0, 32'h0);
    // single-instruction loop
    setup(32'h180, 32'h180, 4);
    walk(32'h180, 7, 1'b0, 1'b0, 32'h0);
    // R10: long loops of four and eight
    setup(32'h200, 32'h206, 3);
    walk(32'h200, 16, 1'b0, 1'b0, 32'h0);
    setup(32'h240, 32'h24E, 2);
    walk(32'h240, 20, 1'b0, 1'b0, 32'h0);
    // R7: not-taken slot at end, R6: taken slot at end
    setup(32'h300, 32'h304, 2);
    walk(32'h300, 5, 1'b1, 1'b0, 32'h0);
    setup(32'h340, 32'h344, 3);
    walk(32'h340, 4, 1'b1, 1'b1, 32'h800);
    chk(loop_act === 1'b1, "R6", "loop kept", {31'd0, loop_act}, 32'd1);
    // R11: class latched, then end moved
    setup(32'h400, 32'h404, 2);
    wr(2'd1, 32'h410);
    walk(32'h400, 20, 1'b0, 1'b0, 32'h0);
    // R12: gaps at the end address
    setup(32'h500, 32'h502, 3);
    step(1'b1, 32'h500, 0, 0, 0, 0, 2'd3, 0, nx);
    step(1'b0, 32'h502, 0, 0, 0, 0, 2'd3, 0, nx);
    step(1'b0, 32'h502, 0, 0, 0, 0, 2'd3, 0, nx);
    walk(32'h502, 8, 1'b0, 1'b0, 32'h0);
    // R3: counter write during the end fetch wins over decrement
    setup(32'h600, 32'h602, 5);
    step(1'b1, 32'h600, 0, 0, 0, 0, 2'd3, 0, nx);
    step(1'b1, 32'h602, 0, 0, 0, 1, 2'd2, 32'd2, nx);
    walk(nx, 6, 1'b0, 1'b0, 32'h0);
    // random loops
    for (int k = 0; k < 200; k++) begin
      logic [31:0] s;
      int len;
      s = 32'h1000 + ($urandom % 256) * 2;
      len = 1 + $urandom % 8;
      setup(s, s + 32'(2 * (len - 1)), 1 + $urandom % 5);
      pc = s;
      for (int i = 0; i < 60; i++) begin
        bit v, sl, tk, we;
        v = ($urandom % 8) != 0;
        sl = ($urandom % 5) == 0;
        tk = sl && (($urandom % 3) == 0);
        we = ($urandom % 50) == 0;
        step(v, pc, sl, tk, m_rs, we, we ? 2'(($urandom % 3)) : 2'd3,
             we ? (($urandom % 2) ? m_rs : 32'($urandom % 6)) : 32'h0, nx);
        pc = nx;
      end
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule